// File: doc/BRIEF.md
# UART Receive Queue with Fill Threshold

This block buffers received UART characters between the character deserializer and the data-register read port. Each incoming word is 16 bits wide: the character sits in the low bits and its per-character flags sit in the upper bits. A read strobe pops the oldest entry. The word presented on the read port carries a valid marker whenever the queue holds data, and it reads as zero when the queue is empty.

The block drives the receiver status bits: threshold-ready, data-ready, empty, a sticky overrun and a sticky break-detect. Interrupt masking of these bits is done elsewhere. The ready flag follows a programmable 6-bit fill level, so software can wait for a burst of characters instead of one. The word that takes the last free slot is tagged in its stored copy as an overrun warning. An accept output tells the receiver whether another character can be stored.

Top module: `uart_rx_fifo`

## Requirements
- R1: The queue holds up to 32 words and returns them in arrival order. `accept` is high exactly when `rx_en` is 1 and fewer than 32 words are stored.
- R2: A word offered with `wr_valid` while 32 words are stored is discarded and sets `st_ore`. `st_ore` stays set until a cycle with `clr_ore` high and no new overrun.
- R3: A word accepted while 31 words are stored is kept with bits 14 (error) and 13 (overrun marker) forced to 1. Other words are kept unchanged.
- R4: After a cycle with `wr_valid`, `st_rrdy` is set if the resulting count is at least `trig_lvl`. After a pop, `st_rrdy` is cleared if the resulting count is below `trig_lvl`.
- R5: `st_rdr` is set by any cycle with `wr_valid`. It is cleared only by a pop that leaves the queue empty. `st_rxempty` is always its complement.
- R6: While the queue is not empty, `rd_word` shows the oldest word with bit 15 set. While it is empty, `rd_word` is 0, and a pop has no effect on the count or the flags.
- R7: An offered word with bit 11 (break) set sets `st_brk`. `st_brk` stays set until a cycle with `clr_brk` high and no new break.
- R8: A push and a pop in the same cycle leave the count unchanged. The flags are evaluated on that unchanged count. When the queue is full at the start of the cycle, the offered word is still discarded.
- R9: After reset the queue is empty, `st_rxempty` is 1, and `st_rrdy`, `st_rdr`, `st_ore` and `st_brk` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable, gates `accept` |
| trig_lvl | input | 6 | Fill level at which `st_rrdy` is raised |
| wr_valid | input | 1 | A received word is offered this cycle |
| wr_word | input | 16 | Received word: character plus flags (bit 11 break) |
| rd_pop | input | 1 | Data-register read: pop the oldest word |
| clr_ore | input | 1 | Clear strobe for `st_ore` |
| clr_brk | input | 1 | Clear strobe for `st_brk` |
| rd_word | output | 16 | Oldest word with bit 15 valid marker, or 0 when empty |
| accept | output | 1 | Receiver may deliver another word |
| st_rrdy | output | 1 | Fill threshold reached |
| st_rdr | output | 1 | At least one word stored |
| st_rxempty | output | 1 | Queue empty |
| st_ore | output | 1 | Sticky overrun |
| st_brk | output | 1 | Sticky break detected |

## Verification
A received word and a data-register read can land in the same cycle. This can happen mid-level, where the count must hold and the threshold flag is judged on the unchanged count. It can also happen on a full queue, where the offered word is still lost and the overrun bit rises while the count drops to 31. The bench drives both pops and pushes on one falling edge and checks the popped word against the scoreboard head. After the edge it checks the flags and the next head against its own model. A following pop shows that the dropped word never reached the queue.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 16,
  parameter int TLW   = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_en,
  input  logic [TLW-1:0] trig_lvl,
  input  logic           wr_valid,
  input  logic [W-1:0]   wr_word,
  input  logic           rd_pop,
  input  logic           clr_ore,
  input  logic           clr_brk,
  output logic [W-1:0]   rd_word,
  output logic           accept,
  output logic           st_rrdy,
  output logic           st_rdr,
  output logic           st_rxempty,
  output logic           st_ore,
  output logic           st_brk
);
  localparam int AW      = $clog2(DEPTH);
  localparam int CW      = $clog2(DEPTH + 1);
  localparam int B_VALID = 15;
  localparam int B_ERR   = 14;
  localparam int B_OVR   = 13;
  localparam int B_BRK   = 11;
  localparam logic [W-1:0] VALID_M = W'(1) << B_VALID;
  localparam logic [W-1:0] LAST_M  = (W'(1) << B_ERR) | (W'(1) << B_OVR);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_nx;
  logic          full, empty, push_ok, pop_ok, lvl_hit, last_slot;
  logic [W-1:0]  store_word;

  assign full       = (cnt == CW'(DEPTH));
  assign empty      = (cnt == '0);
  assign push_ok    = wr_valid && !full;
  assign pop_ok     = rd_pop && !empty;
  assign last_slot  = (cnt == CW'(DEPTH - 1));
  assign store_word = last_slot ? (wr_word | LAST_M) : wr_word;
  assign cnt_nx     = cnt + CW'(push_ok) - CW'(pop_ok);
  assign lvl_hit    = (32'(cnt_nx) >= 32'(trig_lvl));

  assign accept  = rx_en && !full;
  assign rd_word = empty ? '0 : (mem[rp] | VALID_M);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= store_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      cnt <= cnt_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_rrdy    <= 1'b0;
      st_rdr     <= 1'b0;
      st_rxempty <= 1'b1;
    end else begin
      if (wr_valid && pop_ok)  st_rrdy <= lvl_hit;
      else if (wr_valid)       st_rrdy <= st_rrdy | lvl_hit;
      else if (pop_ok)         st_rrdy <= st_rrdy & lvl_hit;

      if (wr_valid) begin
        st_rdr     <= 1'b1;
        st_rxempty <= 1'b0;
      end else if (pop_ok) begin
        st_rdr     <= (cnt_nx != '0);
        st_rxempty <= (cnt_nx == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ore <= 1'b0;
      st_brk <= 1'b0;
    end else begin
      if (wr_valid && full)        st_ore <= 1'b1;
      else if (clr_ore)            st_ore <= 1'b0;
      if (wr_valid && wr_word[B_BRK]) st_brk <= 1'b1;
      else if (clr_brk)            st_brk <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rx_en,
  input logic         wr_valid,
  input logic [W-1:0] wr_word,
  input logic         clr_ore,
  input logic         clr_brk,
  input logic [W-1:0] rd_word,
  input logic         accept,
  input logic         st_rdr,
  input logic         st_rxempty,
  input logic         st_ore,
  input logic         st_brk
);
  // R1
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> rx_en);
  // R2
  full_drop_ore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !accept && wr_valid) |=> st_ore);
  // R2
  ore_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ore && !clr_ore) |=> st_ore);
  // R7
  brk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_brk && !clr_brk) |=> st_brk);
  // R7
  brk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_word[11]) |=> st_brk);
  // R5
  empty_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_rxempty != st_rdr);
  // R6
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_rxempty |-> (rd_word == '0));
  // R6
  valid_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_rdr |-> rd_word[15]);
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .wr_valid(wr_valid),
  .wr_word(wr_word), .clr_ore(clr_ore), .clr_brk(clr_brk),
  .rd_word(rd_word), .accept(accept), .st_rdr(st_rdr),
  .st_rxempty(st_rxempty), .st_ore(st_ore), .st_brk(st_brk)
);

// File: tb/uart_rx_fifo_bench.sv
`timescale 1ns/1ps
module uart_rx_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b1;
  logic [5:0]  trig_lvl = 6'd4;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_word = '0;
  logic        rd_pop = 1'b0;
  logic        clr_ore = 1'b0;
  logic        clr_brk = 1'b0;
  logic [15:0] rd_word;
  logic        accept, st_rrdy, st_rdr, st_rxempty, st_ore, st_brk;

  always #2.5 clk = ~clk;

  uart_rx_fifo u_uart_rx_fifo (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .trig_lvl(trig_lvl),
    .wr_valid(wr_valid), .wr_word(wr_word), .rd_pop(rd_pop),
    .clr_ore(clr_ore), .clr_brk(clr_brk), .rd_word(rd_word),
    .accept(accept), .st_rrdy(st_rrdy), .st_rdr(st_rdr),
    .st_rxempty(st_rxempty), .st_ore(st_ore), .st_brk(st_brk)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] sb[$];
  bit m_rrdy = 0, m_rdr = 0, m_ore = 0, m_brk = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req);
    chk({req, " rrdy"}, 16'(st_rrdy), 16'(m_rrdy));
    chk({req, " rdr"}, 16'(st_rdr), 16'(m_rdr));
    chk({req, " rxempty"}, 16'(st_rxempty), 16'(!m_rdr));
    chk({req, " ore"}, 16'(st_ore), 16'(m_ore));
    chk({req, " brk"}, 16'(st_brk), 16'(m_brk));
    chk({req, " accept"}, 16'(accept), 16'(rx_en && sb.size() < 32));
  endtask

  // driver pushes expected words; the read side compares the head
  task automatic step(input bit wv, input logic [15:0] w, input bit rp, input string req);
    int c;
    bit popok;
    logic [15:0] exp_rd;
    @(negedge clk);
    wr_valid = wv; wr_word = w; rd_pop = rp;
    #0.5;
    c = sb.size();
    exp_rd = (c > 0) ? (sb[0] | 16'h8000) : 16'h0000;
    if (rp) chk({req, " rd_word"}, rd_word, exp_rd);
    popok = rp && c > 0;
    if (popok) void'(sb.pop_front());
    if (wv) begin
      if (c == 32) m_ore = 1;
      else sb.push_back((c == 31) ? (w | 16'h6000) : w);
      if (w[11]) m_brk = 1;
    end
    if (wv && popok)   m_rrdy = (sb.size() >= trig_lvl);
    else if (wv)       m_rrdy = m_rrdy | (sb.size() >= trig_lvl);
    else if (popok)    m_rrdy = m_rrdy & (sb.size() >= trig_lvl);
    if (wv) m_rdr = 1;
    else if (popok) m_rdr = (sb.size() != 0);
    @(posedge clk);
    #1;
    wr_valid = 0; rd_pop = 0;
    chk_flags(req);
  endtask

  task automatic clear(input bit o, input bit b);
    @(negedge clk);
    clr_ore = o; clr_brk = b;
    if (o) m_ore = 0;
    if (b) m_brk = 0;
    @(posedge clk);
    #1;
    clr_ore = 0; clr_brk = 0;
    chk_flags("R2/R7 clear");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9 reset state
    chk_flags("R9");
    chk("R9 rd_word", rd_word, 16'h0000);
    // R4 threshold crossing at 4
    for (int i = 0; i < 4; i++) step(1, 16'h0041 + 16'(i), 0, "R4 fill");
    step(0, 0, 1, "R4 drop below");
    // R8 simultaneous push and pop mid level
    step(1, 16'h0099, 1, "R8 push+pop");
    chk("R8 head", rd_word, sb[0] | 16'h8000);
    // R5 drain to empty, R6 empty read
    while (sb.size() > 0) step(0, 0, 1, "R5 drain");
    step(0, 0, 1, "R6 empty pop");
    chk("R6 empty word", rd_word, 16'h0000);
    // R3 fill to 32, R1 accept drops
    for (int i = 0; i < 32; i++) step(1, 16'h0100 + 16'(i), 0, "R1 fill");
    chk("R3 tag", sb[31], 16'h611F);
    // R2 overrun
    step(1, 16'h00EE, 0, "R2 overrun");
    // R8 push at full with pop: dropped
    step(1, 16'h00DD, 1, "R8 full push+pop");
    chk("R8 count", 16'(sb.size()), 16'd31);
    while (sb.size() > 0) step(0, 0, 1, "R1 order");
    clear(1, 0);
    // R7 break
    step(1, 16'h0800, 0, "R7 break");
    clear(0, 1);
    step(0, 0, 1, "R7 pop");
    // R1 receiver disabled
    rx_en = 0;
    #1 chk("R1 disabled", 16'(accept), 16'd0);
    rx_en = 1;
    // R4 level zero: a push always raises ready
    trig_lvl = 6'd0;
    step(1, 16'h0033, 0, "R4 level0");
    step(0, 0, 1, "R4 level0 pop");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule